// File: doc/BRIEF.md
# Single-Channel Block Copy Engine with Selectable Bus Holding

This block copies a block of words between a memory bus and a streaming peripheral port. The memory bus is shared with a processor. The host programs three values through a small register port: a start address, a word count and a control word. Writing the control word with its go bit set launches the copy.

Before it drives the memory bus, the engine raises a bus request and waits for the processor's acknowledge. For each word it moves, it advances the address by one and lowers the count by one. At run time the host picks one of two modes. In burst mode the engine holds the bus for the whole block. In cycle-stealing mode it gives the bus back after every word and arbitrates again for the next one. Completion sets a sticky done flag, and that flag can raise an interrupt.

The memory returns read data in the same cycle that the address is presented. The peripheral side uses a valid/ready handshake. In the memory-to-peripheral direction the engine offers data. In the peripheral-to-memory direction it accepts data. A word moves only in a cycle where the handshake completes.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, `bus_req`, `mem_en`, `irq`, `per_out_valid` and `per_in_ready` are low, and the status register reads zero.
- R2: After a launch with a nonzero count, `bus_req` rises. No memory strobe (`mem_en`) occurs in any cycle where `bus_ack` is low.
- R3: Each word moved advances the address register by one. The first word uses the programmed start address.
- R4: Each word moved lowers the count register by one. A finished block reads back a count of zero.
- R5: In burst mode (control bit 2 = 1), `bus_req` stays high without a break from the first request to the last word. This holds even while the peripheral stalls the handshake.
- R6: In cycle-stealing mode (control bit 2 = 0), `bus_req` falls after every word. The engine waits for `bus_ack` to go low before it requests again, so an N-word block produces N rising edges of `bus_req`.
- R7: Control bit 1 sets the direction. A value of 0 reads memory and offers words on `per_out_data`, with `mem_we` low. A value of 1 writes the words taken from `per_in_data` into memory, with `mem_we` high.
- R8: After the last word, `bus_req` falls. Once `bus_ack` is low, status bit 0 (busy) clears and status bit 1 (done) sets.
- R9: `irq` equals the done flag ANDed with control bit 3 (interrupt enable). Done stays set until the host writes a 1 to status bit 1. A new launch also clears it.
- R10: A launch with a count of zero raises no bus request. It sets done on the launch edge.
- R11: While busy, writes to the address, count and control registers have no effect, and that includes a second go bit.
- R12: The register map uses `reg_addr` 0 for the address, 1 for the count, 2 for control and 3 for status. In the control register, bit 0 is go (write-only, reads 0), bit 1 is direction, bit 2 is burst and bit 3 is interrupt enable. In the status register, bit 0 is busy and bit 1 is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | RW | Host write data |
| reg_rdata | output | RW | Read data for the selected register |
| bus_req | output | 1 | Memory bus request to the processor |
| bus_ack | input | 1 | Bus granted by the processor |
| mem_en | output | 1 | Memory access strobe, one per word |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| per_out_data | output | DW | Word offered to the peripheral |
| per_out_valid | output | 1 | Word offered to the peripheral |
| per_out_ready | input | 1 | Peripheral takes the offered word |
| per_in_data | input | DW | Word from the peripheral |
| per_in_valid | input | 1 | Peripheral offers a word |
| per_in_ready | output | 1 | Engine takes the offered word |
| irq | output | 1 | Completion interrupt |

## Verification
Faults in the address or count registers show up at the ports within one word. A wrong step puts the next `mem_addr` at the wrong location, and that shows as a misplaced memory word or a wrong word on the peripheral side. A count that does not step shows as too many or too few transfers, and the count register reads back nonzero. A fault in the sequencer state shows as `bus_req` edges that do not match the mode, counted over a whole block, or as a memory strobe while the grant is low in that same cycle. A fault in the done flag or the interrupt gating is visible on `irq` and on the status register as soon as the block ends.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_MOVE = 2'd2,
    ST_REL  = 2'd3
  } dma_state_t;

  localparam logic [1:0] OFS_ADDR  = 2'd0;
  localparam logic [1:0] OFS_COUNT = 2'd1;
  localparam logic [1:0] OFS_CTL   = 2'd2;
  localparam logic [1:0] OFS_STAT  = 2'd3;

  localparam int CTL_GO     = 0;
  localparam int CTL_TO_MEM = 1;
  localparam int CTL_BURST  = 2;
  localparam int CTL_IRQ_EN = 3;

  localparam int STS_BUSY = 0;
  localparam int STS_DONE = 1;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [3:0] wbits,
  input  logic       busy,
  input  logic       done_set,
  output logic       ld_addr,
  output logic       ld_count,
  output logic       go,
  output logic       cfg_to_mem,
  output logic       cfg_burst,
  output logic       cfg_irq_en,
  output logic       done
);
  logic host_ok;
  logic ctl_wr;
  logic done_clr;

  assign host_ok  = reg_wr && !busy;
  assign ld_addr  = host_ok && (reg_addr == OFS_ADDR);
  assign ld_count = host_ok && (reg_addr == OFS_COUNT);
  assign ctl_wr   = host_ok && (reg_addr == OFS_CTL);
  assign go       = ctl_wr && wbits[CTL_GO];
  assign done_clr = (reg_wr && (reg_addr == OFS_STAT) && wbits[STS_DONE]) || go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_to_mem <= 1'b0;
      cfg_burst  <= 1'b0;
      cfg_irq_en <= 1'b0;
    end else if (ctl_wr) begin
      cfg_to_mem <= wbits[CTL_TO_MEM];
      cfg_burst  <= wbits[CTL_BURST];
      cfg_irq_en <= wbits[CTL_IRQ_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b0;
    else if (done_set) done <= 1'b1;
    else if (done_clr) done <= 1'b0;
  end
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_count,
  input  logic [RW-1:0] wdata,
  input  logic          beat,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          count_zero,
  output logic          last_word
);
  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [CW-1:0] count_after(input logic [CW-1:0] c);
    return c - {{(CW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_count <= '0;
    end else begin
      if (ld_addr)   cur_addr <= wdata[AW-1:0];
      else if (beat) cur_addr <= addr_after(cur_addr);
      if (ld_count)  cur_count <= wdata[CW-1:0];
      else if (beat) cur_count <= count_after(cur_count);
    end
  end

  assign count_zero = (cur_count == '0);
  assign last_word  = (cur_count == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       count_zero,
  input  logic       last_word,
  input  logic       cfg_burst,
  input  logic       cfg_to_mem,
  input  logic       bus_ack,
  input  logic       per_out_ready,
  input  logic       per_in_valid,
  output dma_state_t state,
  output logic       bus_req,
  output logic       busy,
  output logic       beat,
  output logic       done_set,
  output logic       mem_en,
  output logic       mem_we,
  output logic       per_out_valid,
  output logic       per_in_ready
);
  dma_state_t nxt;
  logic       move_ok;

  assign move_ok       = (state == ST_MOVE) && bus_ack;
  assign per_out_valid = move_ok && !cfg_to_mem;
  assign per_in_ready  = move_ok && cfg_to_mem;
  assign beat          = cfg_to_mem ? (move_ok && per_in_valid) : (move_ok && per_out_ready);
  assign mem_en        = beat;
  assign mem_we        = beat && cfg_to_mem;
  assign bus_req       = (state == ST_REQ) || (state == ST_MOVE);
  assign busy          = (state != ST_IDLE);

  always_comb begin
    nxt      = state;
    done_set = 1'b0;
    unique case (state)
      ST_IDLE: if (go) begin
        if (count_zero) done_set = 1'b1;
        else            nxt = ST_REQ;
      end
      ST_REQ:  if (bus_ack) nxt = ST_MOVE;
      ST_MOVE: if (beat && (last_word || !cfg_burst)) nxt = ST_REL;
      ST_REL:  if (!bus_ack) begin
        if (count_zero) begin
          nxt      = ST_IDLE;
          done_set = 1'b1;
        end else begin
          nxt = ST_REQ;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int RW = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_ack,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] per_out_data,
  output logic          per_out_valid,
  input  logic          per_out_ready,
  input  logic [DW-1:0] per_in_data,
  input  logic          per_in_valid,
  output logic          per_in_ready,
  output logic          irq
);
  logic          ld_addr, ld_count, go;
  logic          cfg_to_mem, cfg_burst, cfg_irq_en, done;
  logic          busy, beat_w, done_set;
  logic          count_zero, last_word;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_count;
  dma_state_t    state;

  dma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wbits(reg_wdata[3:0]), .busy(busy), .done_set(done_set),
    .ld_addr(ld_addr), .ld_count(ld_count), .go(go),
    .cfg_to_mem(cfg_to_mem), .cfg_burst(cfg_burst), .cfg_irq_en(cfg_irq_en),
    .done(done)
  );

  dma_addr_cnt #(.AW(AW), .CW(CW), .RW(RW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_count(ld_count),
    .wdata(reg_wdata), .beat(beat_w), .cur_addr(cur_addr),
    .cur_count(cur_count), .count_zero(count_zero), .last_word(last_word)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .count_zero(count_zero),
    .last_word(last_word), .cfg_burst(cfg_burst), .cfg_to_mem(cfg_to_mem),
    .bus_ack(bus_ack), .per_out_ready(per_out_ready), .per_in_valid(per_in_valid),
    .state(state), .bus_req(bus_req), .busy(busy), .beat(beat_w),
    .done_set(done_set), .mem_en(mem_en), .mem_we(mem_we),
    .per_out_valid(per_out_valid), .per_in_ready(per_in_ready)
  );

  assign mem_addr     = cur_addr;
  assign mem_wdata    = per_in_data;
  assign per_out_data = mem_rdata;
  assign irq          = done && cfg_irq_en;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_ADDR:  reg_rdata[AW-1:0] = cur_addr;
      OFS_COUNT: reg_rdata[CW-1:0] = cur_count;
      OFS_CTL: begin
        reg_rdata[CTL_TO_MEM] = cfg_to_mem;
        reg_rdata[CTL_BURST]  = cfg_burst;
        reg_rdata[CTL_IRQ_EN] = cfg_irq_en;
      end
      default: begin
        reg_rdata[STS_BUSY] = busy;
        reg_rdata[STS_DONE] = done;
      end
    endcase
  end
endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          mem_en,
  input logic          mem_we,
  input logic          beat_w,
  input logic          busy,
  input logic          done,
  input logic          cfg_burst,
  input logic          cfg_to_mem,
  input logic          cfg_irq_en,
  input logic          irq,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_count
);
  assert_strobe_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> bus_ack);

  assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_w |=> cur_addr == $past(cur_addr) + 1'b1);

  assert_count_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_w |=> cur_count == $past(cur_count) - 1'b1);

  assert_burst_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_w && cfg_burst && cur_count > 1) |=> bus_req);

  assert_steal_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_w && !cfg_burst) |=> !bus_req);

  assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_we == cfg_to_mem));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && cfg_irq_en));

  assert_addr_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd0 && !beat_w) |=> $stable(cur_addr));
endmodule

bind dma_xfer_ctrl dma_xfer_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .mem_en(mem_en), .mem_we(mem_we), .beat_w(beat_w), .busy(busy),
  .done(done), .cfg_burst(cfg_burst), .cfg_to_mem(cfg_to_mem),
  .cfg_irq_en(cfg_irq_en), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cur_addr(cur_addr), .cur_count(cur_count)
);

// File: tb/tb_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_dma_xfer_ctrl;
  localparam int AW = 16, CW = 16, DW = 32, RW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          bus_req, bus_ack, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, per_out_data, per_in_data;
  logic          per_out_valid, per_out_ready, per_in_valid, per_in_ready, irq;

  int total = 0;
  int bad = 0;

  logic ack_en = 1'b1, stall_en = 1'b0, src_en = 1'b0, mem_init = 1'b0;
  logic [7:0]  cyc;
  logic [DW-1:0] mem [0:63];
  logic [DW-1:0] sink [0:15];
  int sink_n, src_idx, req_rises, bad_strobes;
  logic req_d;

  always #4 clk = ~clk;

  dma_xfer_ctrl #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_ack(bus_ack), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_out_data(per_out_data),
    .per_out_valid(per_out_valid), .per_out_ready(per_out_ready),
    .per_in_data(per_in_data), .per_in_valid(per_in_valid),
    .per_in_ready(per_in_ready), .irq(irq)
  );

  assign mem_rdata     = mem[mem_addr[5:0]];
  assign per_out_ready = !stall_en || cyc[1];
  assign per_in_valid  = src_en && (!stall_en || cyc[1]);
  assign per_in_data   = 32'h5000_0000 | src_idx;

  always @(posedge clk) begin
    cyc     <= rst_n ? cyc + 8'd1 : 8'd0;
    bus_ack <= rst_n && ack_en && bus_req;
    req_d   <= rst_n && bus_req;
    if (bus_req && !req_d) req_rises <= req_rises + 1;
    if (mem_en && !bus_ack) bad_strobes <= bad_strobes + 1;
    if (per_out_valid && per_out_ready) begin
      sink[sink_n[3:0]] <= per_out_data;
      sink_n <= sink_n + 1;
    end
    if (per_in_valid && per_in_ready) src_idx <= src_idx + 1;
    if (mem_init) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'hA000_0000 | i;
    end else if (mem_en && mem_we) begin
      mem[mem_addr[5:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    req_rises = 0; sink_n = 0; src_idx = 0; bad_strobes = 0;
  endtask

  task automatic wait_done(input string req);
    logic [RW-1:0] s;
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd(2'd3, s);
      if (s[1]) seen = 1;
    end
    chk(req, {31'd0, seen}, 32'd1);
  endtask

  task automatic t_reset();
    logic [RW-1:0] s;
    chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
    chk("R1 irq/mem_en/valid/ready", {28'd0, irq, mem_en, per_out_valid, per_in_ready}, 32'd0);
    rd(2'd3, s);
    chk("R1 status", {16'd0, s}, 32'd0);
  endtask

  task automatic t_burst_read_stalled();
    logic [RW-1:0] v;
    clear_mon();
    stall_en = 1'b1;
    wr(2'd0, 16'd4);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'h0005);
    wait_done("R8 burst done");
    stall_en = 1'b0;
    for (int i = 0; i < 5; i++) chk("R7/R3 read word", sink[i], 32'hA000_0000 | (4 + i));
    chk("R7 word count out", sink_n, 32'd5);
    chk("R5 single request", req_rises, 32'd1);
    rd(2'd0, v); chk("R3 final addr", {16'd0, v}, 32'd9);
    rd(2'd1, v); chk("R4 final count", {16'd0, v}, 32'd0);
    rd(2'd3, v); chk("R8 status done not busy", {16'd0, v}, 32'd2);
    chk("R8 bus released", {31'd0, bus_req}, 32'd0);
    chk("R9 no irq when disabled", {31'd0, irq}, 32'd0);
    chk("R2 no strobe w/o grant", bad_strobes, 32'd0);
  endtask

  task automatic t_steal_write();
    logic [RW-1:0] v;
    clear_mon();
    src_en = 1'b1;
    wr(2'd0, 16'd20);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h000B);
    wait_done("R8 steal done");
    src_en = 1'b0;
    for (int i = 0; i < 3; i++) chk("R7/R3 mem written", mem[20 + i], 32'h5000_0000 | i);
    chk("R7 neighbour untouched", mem[23], 32'hA000_0017);
    chk("R6 one request per word", req_rises, 32'd3);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    rd(2'd2, v); chk("R12 control readback", {16'd0, v}, 32'h0000_000A);
    wr(2'd3, 16'h0002);
    @(negedge clk);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    rd(2'd3, v); chk("R9 done cleared", {16'd0, v}, 32'd0);
  endtask

  task automatic t_zero_count();
    logic [RW-1:0] v;
    clear_mon();
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0009);
    rd(2'd3, v);
    chk("R10 done at once", {16'd0, v}, 32'd2);
    chk("R10 irq at once", {31'd0, irq}, 32'd1);
    repeat (4) @(negedge clk);
    chk("R10 no request", req_rises, 32'd0);
    wr(2'd3, 16'h0002);
  endtask

  task automatic t_busy_lock();
    logic [RW-1:0] v;
    clear_mon();
    ack_en = 1'b0;
    wr(2'd0, 16'd40);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0005);
    repeat (10) @(negedge clk);
    chk("R2 request waiting", {31'd0, bus_req}, 32'd1);
    chk("R2 no strobe before grant", {31'd0, mem_en}, 32'd0);
    wr(2'd0, 16'h0033);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'h0003);
    rd(2'd0, v); chk("R11 addr kept", {16'd0, v}, 32'd40);
    rd(2'd1, v); chk("R11 count kept", {16'd0, v}, 32'd2);
    rd(2'd2, v); chk("R11 control kept", {16'd0, v}, 32'h0000_0004);
    ack_en = 1'b1;
    wait_done("R8 locked done");
    chk("R11 read direction kept", sink_n, 32'd2);
    chk("R3 words from start addr", sink[1], 32'hA000_0029);
    chk("R2 strobes only with grant", bad_strobes, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    sink_n = 0; src_idx = 0; req_rises = 0; bad_strobes = 0;
    mem_init = 1'b1;
    repeat (3) @(negedge clk);
    mem_init = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_read_stalled();
    t_steal_write();
    t_zero_count();
    t_busy_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule